// File: doc/BRIEF.md
# Programmable Pixel Clock Divider

This block turns a fast parent timing source into the pixel-rate timing for a display channel. It has eight parent inputs, and each one is a one-cycle tick stream on the common core clock. A configuration word picks one parent and sets either a division ratio or a pass-through bypass. Each channel produces two outputs: a one-cycle pixel clock enable (`pix_ce`) that marks the start of every output period, and a pixel level (`pix_lvl`) that shows the duty shape. The division ratio that is currently in force is reported as a plain integer.

The top holds `NUM_CH` independent channels, two by default, one for each display output. Each channel has its own write strobe and shares the write data bus. A written word is held as pending. It is copied into the active setting only when the current output period ends, so a period is never cut short.

Each channel is driven by a three-state phase machine:
- `ST_HIGH` is the first part of a divided period.
- `ST_LOW` is the remainder of the period.
- `ST_BYP` is pass-through.

The transitions are as follows:
- `ST_HIGH` goes to `ST_LOW` once the high tick count has been reached.
- `ST_LOW` goes to `ST_HIGH` or `ST_BYP` on the last tick of the period. This is a reload, and the pending bypass flag chooses the next state.
- `ST_BYP` reloads on every tick and goes to `ST_BYP` or `ST_HIGH`.

Top module: `pixdiv_top`

## Requirements
- R1: The configuration word is 14 bits. Bits [9:0] hold the divisor code, bits [12:10] hold the source select, and bit 13 is bypass. A pulse on `wr_en[c]` captures `wr_data` as the pending word of channel c.
- R2: With bypass clear, a divisor code N gives an output period of N+2 selected ticks, and `ratio_o` reports N+2.
- R3: With bypass set, the divisor code is ignored. `pix_ce` pulses after every selected tick, `pix_lvl` mirrors the selected tick one cycle later, and `ratio_o` reports 1.
- R4: After reset, code, select and bypass are all 0 in both channels. `ratio_o` reads 2, and `pix_ce` and `pix_lvl` are low.
- R5: In a divided period of ratio R, `pix_lvl` is high for floor(R/2) selected ticks and low for the remaining ticks.
- R6: A written setting (ratio, bypass or source) takes effect only at the end of the current output period. The period in progress completes at its old length, and `ratio_o` changes at that boundary.
- R7: Only ticks of the active source (source select value s picks `src_tick[s]`; value 0 is the default parent) advance a channel. With no selected tick, no `pix_ce` is produced.
- R8: Channels are independent. Writing one channel does not change the period or `ratio_o` of another.
- R9: `ratio_o` always lies between 1 and 1025.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 8 | One tick stream per parent source |
| wr_en | input | NUM_CH | Per-channel configuration write strobe |
| wr_data | input | 14 | Configuration word (shared) |
| pix_ce | output | NUM_CH | Period-start enable per channel |
| pix_lvl | output | NUM_CH | Pixel clock level per channel |
| ratio_o | output | 11*NUM_CH | Active division ratio per channel, channel c at [11c+10:11c] |

## Verification
Channel A is swept through divisor codes 0 to 31 plus 511 and 1023, and then through bypass. Every setting is fed by a parent that ticks on every cycle. In this sweep the measured period and high time separate off-by-one errors in the offset encoding, and they separate the odd and even duty split. Channel B runs from a parent that ticks every third cycle. The stretched period shows that only the selected source advances the divider, and a bypass case on B shows that the code is ignored. A rewrite of A in the middle of a period checks that the running period keeps its old length. Meanwhile B's period and ratio are watched to confirm that the two channels do not interact.

// File: rtl/pixdiv_pkg.sv
package pixdiv_pkg;
    localparam int CODE_W  = 10;
    localparam int SEL_W   = 3;
    localparam int NSRC    = 1 << SEL_W;
    localparam int CFG_W   = CODE_W + SEL_W + 1;
    localparam int RATIO_W = $clog2((1 << CODE_W) + 2);
    localparam int MAX_RATIO = (1 << CODE_W) + 1;

    typedef struct packed {
        logic              bypass;
        logic [SEL_W-1:0]  sel;
        logic [CODE_W-1:0] code;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_HIGH = 2'd0,
        ST_LOW  = 2'd1,
        ST_BYP  = 2'd2
    } phase_e;

    function automatic logic [RATIO_W-1:0] ratio_of(cfg_t c);
        if (c.bypass) return RATIO_W'(1);
        return RATIO_W'(c.code) + RATIO_W'(2);
    endfunction
endpackage

// File: rtl/pixdiv_cfg.sv
module pixdiv_cfg
    import pixdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output cfg_t             pend
);
    always_ff @(posedge clk) begin
        if (!rst_n)     pend <= '0;
        else if (wr_en) pend <= cfg_t'(wr_data);
    end
endmodule

// File: rtl/pixdiv_srcsel.sv
module pixdiv_srcsel
    import pixdiv_pkg::*;
(
    input  logic [NSRC-1:0]  src_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    assign tick = src_tick[sel];
endmodule

// File: rtl/pixdiv_core.sv
module pixdiv_core
    import pixdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  cfg_t               pend,
    output logic [SEL_W-1:0]   act_sel,
    output logic               pix_ce,
    output logic               pix_lvl,
    output logic [RATIO_W-1:0] ratio
);
    cfg_t               act_q, act_n;
    phase_e             st_q, st_n;
    logic [RATIO_W-1:0] cnt_q, cnt_n;
    logic [RATIO_W-1:0] hi_cnt;
    logic               reload;

    assign ratio   = ratio_of(act_q);
    assign hi_cnt  = ratio >> 1;
    assign act_sel = act_q.sel;

    always_comb begin
        st_n   = st_q;
        cnt_n  = cnt_q;
        act_n  = act_q;
        reload = 1'b0;
        if (tick) begin
            unique case (st_q)
                ST_BYP:  reload = 1'b1;
                ST_HIGH: begin
                    cnt_n = cnt_q + RATIO_W'(1);
                    if (cnt_q + RATIO_W'(1) == hi_cnt) st_n = ST_LOW;
                end
                ST_LOW: begin
                    if (cnt_q == ratio - RATIO_W'(1)) reload = 1'b1;
                    else cnt_n = cnt_q + RATIO_W'(1);
                end
                default: reload = 1'b1;
            endcase
        end
        if (reload) begin
            act_n = pend;
            cnt_n = '0;
            st_n  = pend.bypass ? ST_BYP : ST_HIGH;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_HIGH;
            cnt_q <= '0;
            act_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            act_q <= act_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_ce  <= 1'b0;
            pix_lvl <= 1'b0;
        end else begin
            pix_ce <= tick && ((st_q == ST_BYP) ||
                               (st_q == ST_HIGH && cnt_q == '0));
            if (st_q == ST_BYP) pix_lvl <= tick;
            else if (tick)      pix_lvl <= (st_q == ST_HIGH);
        end
    end

    // R9
    ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio >= RATIO_W'(1)) && (ratio <= RATIO_W'(MAX_RATIO)));
    // R7
    no_tick_no_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !pix_ce);
    // R6
    mid_period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick || st_q == ST_HIGH) |=> $stable(ratio));
    // R3
    bypass_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BYP && tick) |=> pix_ce);
    // R5
    low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOW) |-> (cnt_q >= hi_cnt && cnt_q < ratio));
endmodule

// File: rtl/pixdiv_top.sv
module pixdiv_top
    import pixdiv_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSRC-1:0]           src_tick,
    input  logic [NUM_CH-1:0]         wr_en,
    input  logic [CFG_W-1:0]          wr_data,
    output logic [NUM_CH-1:0]         pix_ce,
    output logic [NUM_CH-1:0]         pix_lvl,
    output logic [NUM_CH*RATIO_W-1:0] ratio_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cfg_t             pend;
        logic [SEL_W-1:0] sel;
        logic             tick;

        pixdiv_cfg u_cfg (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en[c]),
            .wr_data(wr_data), .pend(pend)
        );
        pixdiv_srcsel u_sel (
            .src_tick(src_tick), .sel(sel), .tick(tick)
        );
        pixdiv_core u_core (
            .clk(clk), .rst_n(rst_n), .tick(tick), .pend(pend),
            .act_sel(sel), .pix_ce(pix_ce[c]), .pix_lvl(pix_lvl[c]),
            .ratio(ratio_o[c*RATIO_W +: RATIO_W])
        );
    end
endmodule

// File: tb/tb_pixdiv_top.sv
module tb_pixdiv_top;
    import pixdiv_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NSRC-1:0]    src_tick = '0;
    logic [1:0]         wr_en = '0;
    logic [CFG_W-1:0]   wr_data = '0;
    logic [1:0]         pix_ce, pix_lvl;
    logic [2*RATIO_W-1:0] ratio_o;

    int nvec = 0, nerr = 0, cyc = 0;

    pixdiv_top #(.NUM_CH(2)) dut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
        .wr_data(wr_data), .pix_ce(pix_ce), .pix_lvl(pix_lvl), .ratio_o(ratio_o)
    );

    always #10 clk = ~clk;

    initial forever @(posedge clk) cyc++;

    // parent 0 ticks every cycle, parent 1 every third cycle, others idle
    initial begin
        int t = 0;
        forever begin
            @(negedge clk);
            t++;
            src_tick = {6'b0, (t % 3 == 0), 1'b1};
        end
    end

    function automatic int ratio_of_ch(int ch);
        return int'(ratio_o[ch*RATIO_W +: RATIO_W]);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input bit byp, input int sel, input int code);
        @(negedge clk);
        wr_en[ch] = 1'b1;
        wr_data = {byp, 3'(sel), 10'(code)};
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic wait_ce(input int ch, output int at);
        do @(negedge clk); while (!pix_ce[ch]);
        at = cyc;
    endtask

    task automatic measure(input int ch, output int per, output int hi);
        int t0;
        wait_ce(ch, t0);
        hi = 0;
        forever begin
            hi += int'(pix_lvl[ch]);
            @(negedge clk);
            if (pix_ce[ch]) break;
        end
        per = cyc - t0;
    endtask

    task automatic run_cfg(input int ch, input bit byp, input int sel, input int code,
                           input int step, input string req);
        int per, hi, r, exp_hi;
        wr(ch, byp, sel, code);
        measure(ch, per, hi);
        measure(ch, per, hi);
        r = byp ? 1 : code + 2;
        exp_hi = byp ? 1 : step * (r / 2);
        check(per == r * step, {req, " period"}, per, r * step);
        check(hi == exp_hi, {req, " R5 high time"}, hi, exp_hi);
        check(ratio_of_ch(ch) == r, {req, " ratio_o"}, ratio_of_ch(ch), r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        int per, hi, t0, t1;
        repeat (3) @(negedge clk);
        // R4 reset state
        check(ratio_of_ch(0) == 2, "R4 ratio A", ratio_of_ch(0), 2);
        check(ratio_of_ch(1) == 2, "R4 ratio B", ratio_of_ch(1), 2);
        check(pix_ce == 2'b00, "R4 ce", int'(pix_ce), 0);
        check(pix_lvl == 2'b00, "R4 lvl", int'(pix_lvl), 0);
        rst_n = 1'b1;
        // R4: divide by two out of reset
        measure(0, per, hi);
        measure(0, per, hi);
        check(per == 2, "R4 default period", per, 2);

        // R1 R2 R5: sweep of codes on channel A, parent 0
        for (int code = 0; code < 32; code++) run_cfg(0, 1'b0, 0, code, 1, "R2");
        run_cfg(0, 1'b0, 0, 511, 1, "R2");
        run_cfg(0, 1'b0, 0, 1023, 1, "R2");
        // R3: bypass ignores the code
        run_cfg(0, 1'b1, 0, 1023, 1, "R3");
        run_cfg(0, 1'b1, 0, 5, 1, "R3");

        // R7: channel B on parent 1 (ticks every third cycle)
        run_cfg(1, 1'b0, 1, 0, 3, "R7");
        run_cfg(1, 1'b0, 1, 3, 3, "R7");
        run_cfg(1, 1'b1, 1, 9, 3, "R7 R3");
        run_cfg(1, 1'b0, 1, 0, 3, "R7");

        // R6: rewrite A mid-period, old period must finish at full length
        run_cfg(0, 1'b0, 0, 8, 1, "R6 setup");
        wait_ce(0, t0);
        repeat (3) @(negedge clk);
        wr(0, 1'b0, 0, 0);
        check(ratio_of_ch(0) == 10, "R6 ratio held", ratio_of_ch(0), 10);
        wait_ce(0, t1);
        check(t1 - t0 == 10, "R6 old period kept", t1 - t0, 10);
        check(ratio_of_ch(0) == 2, "R6 ratio switched", ratio_of_ch(0), 2);
        measure(0, per, hi);
        check(per == 2, "R6 new period", per, 2);

        // R8: B unaffected by writes to A
        wr(0, 1'b0, 0, 20);
        check(ratio_of_ch(1) == 2, "R8 ratio B", ratio_of_ch(1), 2);
        measure(1, per, hi);
        measure(1, per, hi);
        check(per == 6, "R8 period B", per, 6);
        wr(0, 1'b1, 0, 0);
        measure(1, per, hi);
        check(per == 6, "R8 period B after bypass on A", per, 6);
        check(ratio_of_ch(1) == 2, "R8 ratio B after bypass on A", ratio_of_ch(1), 2);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule